// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block is the digital half of a supply supervisor for a battery-backed static memory. Analog comparators outside it report three flags: the supply is above the upper deselect threshold, the supply is below the lower deselect threshold, and the supply is below the battery-switchover level. A periodic timebase tick paces all delays. From these flags the block decides when the memory must be protected. While it is protected, the block gates the external chip-enable, write-enable and output-enable strobes to the memory array, so every access is dropped and the data pins stay undriven. It holds an active-low reset output for the host, selects the battery as the array's power source, and reports a battery-low warning.

Protection is taken when the supply crosses the lower window edge. The supply may fall through the window faster than a minimum fall time, counted in ticks from the moment the supply left the upper threshold. In that case the protection onset is postponed by a fixed number of ticks. On the way back up, protection and the reset output are released together, only after the supply has stayed above the upper threshold for a recovery time in ticks. If the supply dips again before that time ends, the recovery count starts over. Battery selection is separate from protection. It follows the switchover flag with one register stage. The battery-good input is captured only at the end of each power-up recovery.

With the default parameters and a 10 µs tick, the recovery time is 40 ms, the minimum fall time is 300 µs and the late-protection delay is 200 µs.

Top module: `pwrfail_guard`

## Requirements
- R1: After reset, protect_o is 1, rst_n_o is 0, bat_sel_o is 0, bat_low_n_o is 1 and all three memory strobes are 0.
- R2: After the supply leaves the upper threshold, the block counts ticks while sup_low_i is 0. If FALL_MIN_TICKS or more ticks have passed when sup_low_i rises, protect_o goes to 1 at the clock edge that samples sup_low_i high.
- R3: If sup_low_i rises after fewer than FALL_MIN_TICKS such ticks, accesses are still accepted and protect_o rises at the edge that samples the LATE_TICKS-th tick after the crossing.
- R4: While protect_o is 1, mem_ce_o, mem_we_o and mem_oe_o are all 0, whatever the strobe inputs. A write in progress is cut off at the edge where protect_o rises.
- R5: Once protected, protect_o falls and rst_n_o rises at the edge that samples the REC_TICKS-th tick counted while sup_ok_i has stayed 1.
- R6: A low on sup_ok_i during recovery restarts the recovery count from zero.
- R7: rst_n_o is 0 whenever protect_o is 1, including while bat_sel_o is 1.
- R8: bat_sel_o equals sup_bat_i as sampled at the previous clock edge, whether or not the memory is protected.
- R9: bat_low_n_o takes the value of bat_good_i at the edge that ends a recovery (0 means the battery is low) and holds it at every other time.
- R10: If sup_ok_i returns to 1 before sup_low_i rises, the fall is cancelled and the memory is never protected.
- R11: While not protected, mem_ce_o = !ce_n_i, mem_we_o = !ce_n_i & !we_n_i, and mem_oe_o = !ce_n_i & !oe_n_i & we_n_i.
- R12: After a power failure during a write, every memory location except the addressed one keeps its content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse |
| sup_ok_i | input | 1 | Supply above the upper deselect threshold |
| sup_low_i | input | 1 | Supply below the lower deselect threshold |
| sup_bat_i | input | 1 | Supply below the battery-switchover level |
| bat_good_i | input | 1 | Battery voltage adequate |
| ce_n_i | input | 1 | External chip enable, active low |
| we_n_i | input | 1 | External write enable, active low |
| oe_n_i | input | 1 | External output enable, active low |
| protect_o | output | 1 | Memory deselected and write-protected |
| bat_sel_o | output | 1 | Array powered from the battery |
| rst_n_o | output | 1 | Host reset, active low (open-drain model) |
| bat_low_n_o | output | 1 | Battery-low warning, low when asserted (open-drain model) |
| mem_ce_o | output | 1 | Gated chip enable to the array, active high |
| mem_we_o | output | 1 | Gated write enable to the array, active high |
| mem_oe_o | output | 1 | Gated output enable to the array, active high |

## Verification
The embedded properties check several rules on every cycle. Strobes stay blocked under protection, and accesses pass through when the block is unprotected. Protection is never released without a tick while the supply is good, and never while the supply is low. No onset occurs without a lower-threshold crossing or an expired late delay, and none during a tick-free late cycle. The battery selection lags by one register stage, and the battery-low flag moves only on a recovery release. The exact tick counts need the bench's directed scenarios. These are the slow-fall versus fast-fall split, the postponed onset, the recovery length and its restart. So do the sampling of the battery flag at power-up only and the survival of every byte except the addressed one across a failure in mid-write.

// File: rtl/pwrfail_pkg.sv
package pwrfail_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,   // accesses accepted
        ST_WIN   = 3'd1,   // supply inside the deselect window, fall timed
        ST_LATE  = 3'd2,   // fast fall, protection onset postponed
        ST_PROT  = 3'd3,   // protected, supply not yet good
        ST_RECOV = 3'd4    // protected, recovery time running
    } pf_state_e;

endpackage

// File: rtl/pwrfail_seq.sv
module pwrfail_seq
    import pwrfail_pkg::*;
#(
    parameter int REC_TICKS      = 4000,
    parameter int FALL_MIN_TICKS = 30,
    parameter int LATE_TICKS     = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sup_ok,
    input  logic sup_low,
    output logic protect_o,
    output logic release_o
);
    localparam int MAXC = (REC_TICKS > FALL_MIN_TICKS)
                        ? ((REC_TICKS > LATE_TICKS) ? REC_TICKS : LATE_TICKS)
                        : ((FALL_MIN_TICKS > LATE_TICKS) ? FALL_MIN_TICKS : LATE_TICKS);
    localparam int CW = $clog2(MAXC + 1);
    localparam logic [CW-1:0] REC_LAST  = CW'(REC_TICKS - 1);
    localparam logic [CW-1:0] LATE_LAST = CW'(LATE_TICKS - 1);
    localparam logic [CW-1:0] FALL_MIN  = CW'(FALL_MIN_TICKS);

    typedef struct packed {
        pf_state_e       st;
        logic [CW-1:0]   cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            ST_RUN: begin
                if (sup_low) begin
                    seq_d.st  = ST_LATE;
                    seq_d.cnt = '0;
                end else if (!sup_ok) begin
                    seq_d.st  = ST_WIN;
                    seq_d.cnt = '0;
                end
            end
            ST_WIN: begin
                if (sup_low) begin
                    seq_d.st  = (seq_q.cnt >= FALL_MIN) ? ST_PROT : ST_LATE;
                    seq_d.cnt = '0;
                end else if (sup_ok) begin
                    seq_d.st  = ST_RUN;
                    seq_d.cnt = '0;
                end else if (tick && (seq_q.cnt < FALL_MIN)) begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_LATE: begin
                if (tick) begin
                    if (seq_q.cnt == LATE_LAST) begin
                        seq_d.st  = ST_PROT;
                        seq_d.cnt = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            ST_PROT: begin
                if (sup_ok) begin
                    seq_d.st  = ST_RECOV;
                    seq_d.cnt = '0;
                end
            end
            ST_RECOV: begin
                if (!sup_ok) begin
                    seq_d.st  = ST_PROT;
                    seq_d.cnt = '0;
                end else if (tick) begin
                    if (seq_q.cnt == REC_LAST) begin
                        seq_d.st  = ST_RUN;
                        seq_d.cnt = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                seq_d.st  = ST_PROT;
                seq_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_PROT, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign protect_o = (seq_q.st == ST_PROT) || (seq_q.st == ST_RECOV);
    assign release_o = (seq_q.st == ST_RECOV) && (seq_d.st == ST_RUN);

    // R5
    release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(protect_o) |-> ($past(tick) && $past(sup_ok)));

    // R6
    hold_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (protect_o && !sup_ok) |=> protect_o);

    // R2
    onset_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(protect_o) |-> ($past(sup_low) || ($past(seq_q.st) == ST_LATE)));

    // R3
    late_no_onset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.st == ST_LATE) && !tick) |=> !protect_o);

endmodule

// File: rtl/pwrfail_gate.sv
module pwrfail_gate (
    input  logic protect,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic mem_ce,
    output logic mem_we,
    output logic mem_oe
);
    logic sel;

    always_comb begin
        sel    = !protect && !ce_n;
        mem_ce = sel;
        mem_we = sel && !we_n;
        mem_oe = sel && !oe_n && we_n;
    end

endmodule

// File: rtl/pwrfail_batt.sv
module pwrfail_batt (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_bat,
    input  logic bat_good,
    input  logic release_i,
    output logic bat_sel_o,
    output logic bat_low_n_o
);
    typedef struct packed {
        logic bat_sel;
        logic low;
    } batt_t;

    batt_t batt_d, batt_q;

    always_comb begin
        batt_d         = batt_q;
        batt_d.bat_sel = sup_bat;
        if (release_i) begin
            batt_d.low = !bat_good;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            batt_q <= '{bat_sel: 1'b0, low: 1'b0};
        end else begin
            batt_q <= batt_d;
        end
    end

    assign bat_sel_o   = batt_q.bat_sel;
    assign bat_low_n_o = !batt_q.low;

    // R8
    bat_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (bat_sel_o == $past(sup_bat)));

    // R9
    low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !release_i |=> $stable(bat_low_n_o));

endmodule

// File: rtl/pwrfail_guard.sv
module pwrfail_guard #(
    parameter int REC_TICKS      = 4000,
    parameter int FALL_MIN_TICKS = 30,
    parameter int LATE_TICKS     = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sup_ok_i,
    input  logic sup_low_i,
    input  logic sup_bat_i,
    input  logic bat_good_i,
    input  logic ce_n_i,
    input  logic we_n_i,
    input  logic oe_n_i,
    output logic protect_o,
    output logic bat_sel_o,
    output logic rst_n_o,
    output logic bat_low_n_o,
    output logic mem_ce_o,
    output logic mem_we_o,
    output logic mem_oe_o
);
    logic prot_w;
    logic rel_w;

    pwrfail_seq #(
        .REC_TICKS      (REC_TICKS),
        .FALL_MIN_TICKS (FALL_MIN_TICKS),
        .LATE_TICKS     (LATE_TICKS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .sup_ok    (sup_ok_i),
        .sup_low   (sup_low_i),
        .protect_o (prot_w),
        .release_o (rel_w)
    );

    pwrfail_gate u_gate (
        .protect (prot_w),
        .ce_n    (ce_n_i),
        .we_n    (we_n_i),
        .oe_n    (oe_n_i),
        .mem_ce  (mem_ce_o),
        .mem_we  (mem_we_o),
        .mem_oe  (mem_oe_o)
    );

    pwrfail_batt u_batt (
        .clk         (clk),
        .rst_n       (rst_n),
        .sup_bat     (sup_bat_i),
        .bat_good    (bat_good_i),
        .release_i   (rel_w),
        .bat_sel_o   (bat_sel_o),
        .bat_low_n_o (bat_low_n_o)
    );

    assign protect_o = prot_w;
    assign rst_n_o   = !prot_w;

    // R4
    blocked_when_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_w |-> (!mem_ce_o && !mem_we_o && !mem_oe_o));

    // R11
    write_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_w && !ce_n_i && !we_n_i) |-> mem_we_o);

endmodule

// File: tb/sim_pwrfail_guard.sv
module sim_pwrfail_guard;
    localparam int CLK_PERIOD = 10;
    localparam int REC  = 10;
    localparam int FMIN = 6;
    localparam int LATE = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic sup_ok = 1'b0, sup_low = 1'b1, sup_bat = 1'b0, bat_good = 1'b1;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic protect, bat_sel, rst_out_n, bat_low_n, mem_ce, mem_we, mem_oe;

    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] mem [16];
    logic [7:0] exp_mem [16];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrfail_guard #(.REC_TICKS(REC), .FALL_MIN_TICKS(FMIN), .LATE_TICKS(LATE)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .sup_ok_i(sup_ok), .sup_low_i(sup_low), .sup_bat_i(sup_bat),
        .bat_good_i(bat_good), .ce_n_i(ce_n), .we_n_i(we_n), .oe_n_i(oe_n),
        .protect_o(protect), .bat_sel_o(bat_sel), .rst_n_o(rst_out_n),
        .bat_low_n_o(bat_low_n), .mem_ce_o(mem_ce), .mem_we_o(mem_we), .mem_oe_o(mem_oe)
    );

    // behavioural array behind the gated strobes
    always @(posedge clk) if (mem_we) mem[addr] <= wdata;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock cycle: inputs set before the edge, outputs sampled at the next falling edge
    task automatic cyc(input bit t);
        tick = t;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 protect", protect, 1);
        chk("R1 rst_n_o", rst_out_n, 0);
        chk("R1 bat_sel", bat_sel, 0);
        chk("R1 bat_low_n", bat_low_n, 1);
        chk("R1 strobes", {mem_ce, mem_we, mem_oe}, 0);
    endtask

    task automatic t_power_up();
        sup_low = 1'b0;
        sup_ok  = 1'b1;
        cyc(0);
        for (int i = 0; i < REC - 1; i++) cyc(1);
        chk("R5 still protected before last tick", protect, 1);
        cyc(1);
        chk("R5 released", protect, 0);
        chk("R5 reset released", rst_out_n, 1);
        chk("R9 battery good sampled", bat_low_n, 1);
    endtask

    task automatic t_access();
        addr = 4'd2; wdata = 8'h3C; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        #1;
        chk("R11 write strobes", {mem_ce, mem_we, mem_oe}, 3'b110);
        cyc(0);
        exp_mem[2] = 8'h3C;
        chk("R11 write landed", mem[2], 8'h3C);
        we_n = 1'b1; oe_n = 1'b0;
        #1;
        chk("R11 read strobes", {mem_ce, mem_we, mem_oe}, 3'b101);
        ce_n = 1'b1; oe_n = 1'b1;
        #1;
        chk("R11 deselected", {mem_ce, mem_we, mem_oe}, 3'b000);
    endtask

    task automatic t_bat_follow();
        sup_bat = 1'b1;
        #1;
        chk("R8 no change before edge", bat_sel, 0);
        cyc(0);
        chk("R8 follows while unprotected", bat_sel, 1);
        chk("R8 no protection from battery flag", protect, 0);
        sup_bat = 1'b0;
        cyc(0);
        chk("R8 follows back", bat_sel, 0);
    endtask

    task automatic t_cancel();
        sup_ok = 1'b0;
        for (int i = 0; i < FMIN + 2; i++) cyc(1);
        chk("R10 window alone does not protect", protect, 0);
        sup_ok = 1'b1;
        cyc(1);
        cyc(1);
        chk("R10 fall cancelled", protect, 0);
        ce_n = 1'b0;
        #1;
        chk("R10 accesses still pass", mem_ce, 1);
        ce_n = 1'b1;
    endtask

    task automatic t_slow_fall();
        sup_ok = 1'b0;
        cyc(0);
        for (int i = 0; i < FMIN; i++) cyc(1);
        addr = 4'd5; wdata = 8'hA5; ce_n = 1'b0; we_n = 1'b0;
        #1;
        chk("R2 unprotected before crossing", protect, 0);
        chk("R4 write in progress", mem_we, 1);
        sup_low = 1'b1;
        cyc(0);
        chk("R2 protected at crossing edge", protect, 1);
        chk("R4 write cut off", mem_we, 0);
        addr = 4'd3; wdata = 8'hFF;
        cyc(1);
        addr = 4'd9;
        cyc(0);
        chk("R4 strobes blocked", {mem_ce, mem_we, mem_oe}, 0);
        for (int i = 0; i < 16; i++) begin
            if (i != 5) chk("R12 other bytes intact", mem[i], exp_mem[i]);
        end
        ce_n = 1'b1; we_n = 1'b1;
        exp_mem[5] = mem[5];
        sup_bat = 1'b1;
        cyc(0);
        chk("R8 battery selected", bat_sel, 1);
        chk("R7 reset held on battery", rst_out_n, 0);
    endtask

    task automatic t_restart();
        sup_bat = 1'b0; sup_low = 1'b0; sup_ok = 1'b1; bat_good = 1'b0;
        cyc(0);
        for (int i = 0; i < REC - 2; i++) cyc(1);
        sup_ok = 1'b0;
        cyc(0);
        chk("R6 dip keeps protection", protect, 1);
        sup_ok = 1'b1;
        cyc(0);
        for (int i = 0; i < REC - 1; i++) cyc(1);
        chk("R6 count restarted", protect, 1);
        chk("R9 flag held during recovery", bat_low_n, 1);
        cyc(1);
        chk("R5 released after full recovery", protect, 0);
        chk("R9 battery low sampled", bat_low_n, 0);
        bat_good = 1'b1;
        cyc(1);
        cyc(0);
        chk("R9 not resampled while running", bat_low_n, 0);
    endtask

    task automatic t_fast_fall();
        sup_ok = 1'b0;
        cyc(0);
        cyc(1);
        cyc(1);
        sup_low = 1'b1;
        cyc(0);
        chk("R3 onset postponed", protect, 0);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1;
        chk("R3 reads accepted while postponed", mem_oe, 1);
        for (int i = 0; i < LATE - 1; i++) cyc(1);
        chk("R3 still unprotected", protect, 0);
        cyc(1);
        chk("R3 protected after late delay", protect, 1);
        chk("R4 read blocked", mem_oe, 0);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i]     = 8'(i * 17);
            exp_mem[i] = 8'(i * 17);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_power_up();
        t_access();
        t_bat_follow();
        t_cancel();
        t_slow_fall();
        t_restart();
        t_fast_fall();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule